// File: doc/BRIEF.md
# Settled-Distortion Harmonic Order Sweeper

This block walks a harmonic-order value upward through a fixed range and, for each order, waits until an external distortion measurement has stopped moving before it steps on. The current order is driven out continuously so that a downstream conduction-angle generator can act on it. The distortion figure arrives as a stream of strobed unsigned Q1.15 fractions, and producing that figure is left to other logic.

An order counts as settled when enough sample-to-sample steps have fallen inside a programmable tolerance. At that point the sample that completed the count is offered to a running minimum search. The smallest settled distortion and the order that produced it are held on the outputs. When the last order settles, the sweep stops and a completion flag rises. A start pulse begins a new sweep at any time.

Top module: `sweep_tracker`

## Requirements
- R1: After reset the order output is 2, the minimum output is 16'hFFFF, the best-order output is 2 and done is low.
- R2: A start pulse, accepted even in the middle of a sweep, makes the next cycle show order 2, minimum 16'hFFFF, best order 2 and done low. It also clears the settle count and the held reference sample.
- R3: After each start and after each order step, the first accepted sample only becomes the reference for later comparisons. It never adds to the settle count.
- R4: Every later accepted sample is compared with the previous accepted sample using the absolute difference. A difference strictly below the tolerance input adds one to the settle count. A difference equal to or above the tolerance leaves the count unchanged and does not clear it.
- R5: When the settle count reaches the threshold input, the count returns to zero and the order advances by exactly one, visible the cycle after that sample.
- R6: At each settle the completing sample replaces the held minimum only if it is strictly smaller, and the best order then takes the order that was current. On a tie the earlier, lower order is kept.
- R7: The settle at order 120 raises done. From then on the order stays at 120, and samples change none of the outputs until the next start.
- R8: A threshold input of 0 behaves like a threshold of 1.
- R9: Cycles with the valid strobe low, and samples offered before the first start, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that (re)starts the sweep |
| smp_valid | input | 1 | Distortion sample strobe |
| smp_data | input | 16 | Distortion sample, unsigned Q1.15 |
| tol | input | 16 | Step tolerance, same scale as the sample |
| settle_thr | input | 16 | Number of in-tolerance steps that settle an order |
| order_m | output | 7 | Current harmonic order |
| min_dist | output | 16 | Smallest settled distortion so far |
| best_m | output | 7 | Order that produced min_dist |
| done | output | 1 | Sweep finished |

## Verification
On every cycle the assertions check these rules: the order moves only by a single step or back to 2; the minimum never rises except at a start; the best order never exceeds the current one; a start produces the cleared state; and idle cycles, or cycles after completion, leave the outputs unchanged. Other rules depend on a sequence of sample values and only the bench scenarios can show them. These are the reference sample being skipped, out-of-tolerance steps keeping a partial count, tie handling at an equal later minimum, the zero-threshold case, and the final result of a full 2-to-120 sweep over a V-shaped distortion curve.

// File: rtl/hst_pkg.sv
package hst_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    localparam int SAMPLE_W = 16;

endpackage

// File: rtl/hst_delta.sv
// Holds the previous accepted sample and reports whether the new one lies
// within tolerance of it.
module hst_delta #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         take,
    input  logic [W-1:0] sample,
    input  logic [W-1:0] tol,
    output logic         near,
    output logic         primed
);

    typedef struct packed {
        logic         have;
        logic [W-1:0] prev;
    } dstate_t;

    dstate_t st_d, st_q;
    logic [W-1:0] gap;

    always_comb begin
        gap  = (sample >= st_q.prev) ? (sample - st_q.prev) : (st_q.prev - sample);
        near = take && st_q.have && (gap < tol);

        st_d = st_q;
        if (take) begin
            st_d.prev = sample;
            st_d.have = 1'b1;
        end
        if (flush) begin
            st_d.have = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign primed = st_q.have;

endmodule

// File: rtl/hst_settle.sv
// Counts in-tolerance steps and flags the step that reaches the threshold.
module hst_settle #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          bump,
    input  logic [CW-1:0] thr,
    output logic          hit
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } sstate_t;

    sstate_t st_d, st_q;
    logic [CW:0] next_cnt;
    logic [CW:0] thr_eff;

    always_comb begin
        thr_eff  = (thr == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, thr};
        next_cnt = {1'b0, st_q.cnt} + {{CW{1'b0}}, 1'b1};
        hit      = bump && (next_cnt == thr_eff);

        st_d = st_q;
        if (bump) begin
            st_d.cnt = next_cnt[CW-1:0];
        end
        if (hit || clear) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/hst_argmin.sv
// Running minimum of offered values with the order that produced it.
module hst_argmin #(
    parameter int W     = 16,
    parameter int MW    = 7,
    parameter int M_MIN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          offer,
    input  logic [W-1:0]  value,
    input  logic [MW-1:0] order,
    output logic [W-1:0]  min_val,
    output logic [MW-1:0] min_ord
);

    localparam logic [MW-1:0] ORD_INIT = MW'(M_MIN);

    typedef struct packed {
        logic [W-1:0]  mv;
        logic [MW-1:0] mo;
    } astate_t;

    astate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (init) begin
            st_d.mv = '1;
            st_d.mo = ORD_INIT;
        end else if (offer && (value < st_q.mv)) begin
            st_d.mv = value;
            st_d.mo = order;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mv <= '1;
            st_q.mo <= ORD_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign min_val = st_q.mv;
    assign min_ord = st_q.mo;

endmodule

// File: rtl/sweep_tracker.sv
// Top: sequences the harmonic order from M_MIN to M_MAX, stepping on settle.
module sweep_tracker #(
    parameter int SW    = hst_pkg::SAMPLE_W,
    parameter int CW    = 16,
    parameter int M_MIN = 2,
    parameter int M_MAX = 120,
    parameter int MW    = $clog2(M_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          smp_valid,
    input  logic [SW-1:0] smp_data,
    input  logic [SW-1:0] tol,
    input  logic [CW-1:0] settle_thr,
    output logic [MW-1:0] order_m,
    output logic [SW-1:0] min_dist,
    output logic [MW-1:0] best_m,
    output logic          done
);

    import hst_pkg::*;

    localparam logic [MW-1:0] ORD_LO = MW'(M_MIN);
    localparam logic [MW-1:0] ORD_HI = MW'(M_MAX);

    typedef struct packed {
        phase_e        ph;
        logic [MW-1:0] ord;
    } tstate_t;

    tstate_t st_d, st_q;

    logic take;
    logic near;
    logic primed;
    logic hit;

    assign take = smp_valid && !start && (st_q.ph == PH_RUN);

    hst_delta #(.W(SW)) u_delta (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (start || hit),
        .take   (take),
        .sample (smp_data),
        .tol    (tol),
        .near   (near),
        .primed (primed)
    );

    hst_settle #(.CW(CW)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .bump  (near),
        .thr   (settle_thr),
        .hit   (hit)
    );

    hst_argmin #(.W(SW), .MW(MW), .M_MIN(M_MIN)) u_argmin (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (start),
        .offer   (hit),
        .value   (smp_data),
        .order   (st_q.ord),
        .min_val (min_dist),
        .min_ord (best_m)
    );

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.ph  = PH_RUN;
            st_d.ord = ORD_LO;
        end else if (hit) begin
            if (st_q.ord == ORD_HI) begin
                st_d.ph = PH_DONE;
            end else begin
                st_d.ord = st_q.ord + MW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= PH_IDLE;
            st_q.ord <= ORD_LO;
        end else begin
            st_q <= st_d;
        end
    end

    assign order_m = st_q.ord;
    assign done    = (st_q.ph == PH_DONE);

    logic unused_primed;
    assign unused_primed = primed;

endmodule

// File: rtl/sweep_tracker_chk.sv
module sweep_tracker_chk #(
    parameter int SW    = 16,
    parameter int M_MIN = 2,
    parameter int MW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          smp_valid,
    input logic [MW-1:0] order_m,
    input logic [SW-1:0] min_dist,
    input logic [MW-1:0] best_m,
    input logic          done
);

    // R5
    order_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(order_m) |-> (order_m == $past(order_m) + MW'(1)) || (order_m == MW'(M_MIN)));

    // R6
    min_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start) |-> (min_dist <= $past(min_dist)));

    // R6
    best_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        best_m <= order_m);

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (order_m == MW'(M_MIN)) && (best_m == MW'(M_MIN)) && (min_dist == '1) && !done);

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(order_m) && $stable(min_dist) && $stable(best_m));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !start) |=> $stable(order_m) && $stable(min_dist) && $stable(best_m) && $stable(done));

endmodule

bind sweep_tracker sweep_tracker_chk #(.SW(SW), .M_MIN(M_MIN), .MW(MW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .smp_valid (smp_valid),
    .order_m   (order_m),
    .min_dist  (min_dist),
    .best_m    (best_m),
    .done      (done)
);

// File: tb/sweep_tracker_bench.sv
`timescale 1ns/1ps
module sweep_tracker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [15:0] tol = 16'd33;
    logic [15:0] settle_thr = 16'd3;
    logic [6:0]  order_m;
    logic [15:0] min_dist;
    logic [6:0]  best_m;
    logic        done;

    always #2.5 clk = ~clk;

    sweep_tracker u_sweep_tracker (
        .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid),
        .smp_data(smp_data), .tol(tol), .settle_thr(settle_thr),
        .order_m(order_m), .min_dist(min_dist), .best_m(best_m), .done(done)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // reference model state
    int  mm = 2, mn = 16'hFFFF, bm = 2, cnt = 0, prev = 0;
    bit  dn = 0, run = 0, hp = 0;

    logic [30:0] exp_q[$];
    string       tag_q[$];

    function automatic logic [30:0] pack_exp();
        return {7'(mm), 16'(mn), 7'(bm), dn};
    endfunction

    task automatic check_now(input logic [30:0] e, input string tag);
        checks++;
        if ({order_m, min_dist, best_m, done} !== e) begin
            errors++;
            $display("FAIL %s: got m=%0d min=%0d best=%0d done=%0d, expected m=%0d min=%0d best=%0d done=%0d",
                     tag, order_m, min_dist, best_m, done, e[30:24], e[23:8], e[7:1], e[0]);
        end
    endtask

    task automatic model_sample(input int v);
        int d, c, te;
        if (!run) return;
        if (!hp) begin hp = 1; prev = v; return; end
        d = (v > prev) ? v - prev : prev - v;
        prev = v;
        if (d < int'(tol)) begin
            c  = cnt + 1;
            te = (settle_thr == 0) ? 1 : int'(settle_thr);
            if (c == te) begin
                cnt = 0; hp = 0;
                if (v < mn) begin mn = v; bm = mm; end
                if (mm == 120) begin dn = 1; run = 0; end
                else mm++;
            end else cnt = c;
        end
    endtask

    task automatic send(input int v, input string tag);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = 16'(v);
        @(posedge clk);
        model_sample(v);
        #1 smp_valid = 1'b0;
        exp_q.push_back(pack_exp()); tag_q.push_back(tag);
    endtask

    task automatic gap(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b0; smp_data = 16'(i * 977);
            @(posedge clk);
            #1;
            exp_q.push_back(pack_exp()); tag_q.push_back(tag);
        end
    endtask

    task automatic pulse_start(input string tag);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        run = 1; dn = 0; mm = 2; mn = 16'hFFFF; bm = 2; cnt = 0; hp = 0;
        #1 start = 1'b0;
        exp_q.push_back(pack_exp()); tag_q.push_back(tag);
    endtask

    function automatic int curve(input int m);
        if (m == 40) return 1239;
        return 1239 + 37 * ((m > 24) ? m - 24 : 24 - m);
    endfunction

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) check_now(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_now({7'd2, 16'hFFFF, 7'd2, 1'b0}, "R1 reset state");
        rst_n = 1'b1;

        // R9: samples before any start do nothing
        send(100, "R9 idle sample"); send(5000, "R9 idle sample");

        pulse_start("R2 start clears");

        // R3/R4: reference skipped, out-of-tolerance step keeps partial count
        send(1000, "R3 reference only");
        send(1010, "R4 in tolerance");
        send(2000, "R4 big step keeps count");
        send(2005, "R4 in tolerance");
        send(2010, "R5 settle advances");
        @(negedge clk);
        check_now({7'd3, 16'd2010, 7'd2, 1'b0}, "R5 order 3 after settle");

        // full sweep restart
        pulse_start("R2 restart");
        for (int m = 2; m <= 120; m++) begin
            int v;
            v = curve(m);
            send(v + 500, "R3 reference");
            send(v + 3,   "R4 step above tol");
            if (m % 7 == 0) gap(2, "R9 valid low");
            send(v + 1,   "R4 count");
            send(v,       "R4 count");
            send(v,       "R6 settle sample");
        end
        @(negedge clk);
        check_now({7'd120, 16'd1239, 7'd24, 1'b1}, "R6 optimum 24 with tie at 40 kept earlier");

        // R7: after done nothing moves
        send(10, "R7 ignored after done"); send(10, "R7 ignored after done");
        send(10, "R7 ignored after done");
        @(negedge clk);
        check_now({7'd120, 16'd1239, 7'd24, 1'b1}, "R7 outputs held");

        // R8: threshold zero acts as one
        settle_thr = 16'd0;
        pulse_start("R2 start with zero threshold");
        send(500, "R8 reference");
        send(500, "R8 one step settles");
        @(negedge clk);
        check_now({7'd3, 16'd500, 7'd2, 1'b0}, "R8 zero threshold advanced");

        // R10-style restart mid sweep is R2
        settle_thr = 16'd2;
        send(400, "R3 reference"); send(401, "R4 count");
        pulse_start("R2 mid-sweep restart");
        send(300, "R3 reference after restart");
        @(negedge clk);
        check_now({7'd2, 16'hFFFF, 7'd2, 1'b0}, "R3 reference does not settle");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule